// File: doc/BRIEF.md
# Three-Channel Capture and Waveform Timer

This block contains three identical 16-bit timer channels. Each channel runs on its own in one of two modes. In capture mode, chosen edges on the channel's input latch the running count into two capture registers, taking turns between them. Software then works out pulse widths, periods or intervals from the difference. In waveform mode, the count is compared against two programmable values. One value raises the channel output and the other lowers it and restarts the count, so the channel produces a PWM signal, a single pulse or a programmable delay.

Each channel selects what advances its counter. The choices are:
- every clock cycle;
- a tick from a shared fixed divider;
- rising edges of the channel's own input, for event counting;
- the one-cycle overflow pulse of the preceding channel. Channel 0 takes this pulse from the last channel, so channels can be cascaded into wider counters.

A single global start input clears and restarts every channel in the same clock cycle.

Top module: `tri_timer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every count, capture register, waveform output, overflow flag and overflow pulse becomes 0. The divider phase also restarts at 0.
- R2: An enabled channel adds one to its count on every rising edge at which its selected tick is present. A count of 0xFFFF moves to 0.
- R3: `trig_i[i]` or `sync_start_i`, when high at an edge, sets the channel's count, waveform output and overflow flag to 0. It also points the next capture at register A. This takes priority over counting and capturing, and `sync_start_i` acts on all channels at the same edge.
- R4: A channel whose `enable_i` bit is low keeps its count and waveform output, and takes no capture.
- R5: In capture mode, the edge select of the channel picks the qualifying edges: 2'b01 rising, 2'b10 falling, 2'b11 both, 2'b00 none. An edge qualifies when the input differs from its value at the previous edge. The first qualifying edge after a clear stores the pre-edge count in capture A, the next stores it in capture B, and the two then alternate.
- R6: In waveform mode, a tick while the count equals compare A sets the output. A tick while the count equals compare C clears the output and returns the count to 0. When both match, C wins.
- R7: A move from 0xFFFF to 0 that is not a compare-C restart sets a sticky overflow flag. It also raises the overflow pulse for exactly the following cycle.
- R8: Clock select per channel: 2'b00 every cycle; 2'b01 once every DIV_RATIO cycles, from a divider that runs freely since reset; 2'b10 the overflow pulse of channel i-1, with channel 0 using the last channel; 2'b11 rising edges of the channel's own input.
- R9: Mode bit per channel: 0 selects capture, 1 selects waveform. Each channel uses its own mode, unaffected by the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_start_i | input | 1 | Clear and restart all channels together |
| enable_i | input | 3 | Per-channel run enable |
| trig_i | input | 3 | Per-channel clear |
| wave_mode_i | input | 3 | Per-channel mode, 1 = waveform |
| clk_sel_i | input | 6 | Two-bit tick source per channel |
| edge_sel_i | input | 6 | Two-bit capture edge select per channel |
| tin_i | input | 3 | Per-channel external input |
| cmp_a_i | input | 48 | Per-channel compare A |
| cmp_c_i | input | 48 | Per-channel compare C |
| count_o | output | 48 | Per-channel count |
| cap_a_o | output | 48 | Per-channel capture A |
| cap_b_o | output | 48 | Per-channel capture B |
| wave_o | output | 3 | Per-channel waveform output |
| ovf_flag_o | output | 3 | Per-channel sticky overflow flag |
| ovf_pulse_o | output | 3 | Per-channel one-cycle overflow pulse |

## Verification
The hardest situation to reach from the ports is a counter wrap and the chained tick that follows it. Both need 65536 ticks with no trigger, and a cascaded channel sees nothing until then. The stimulus clears all channels together with the global start and lets channel 0 run on every cycle for a full wrap. Meanwhile channel 1 is chained to it and channel 2 counts toggles on its own input. A behavioural model is compared with every output on every clock throughout the run. Directed checks land on the exact cycle of the wrap and on the one after it.

// File: rtl/tri_timer_pkg.sv
// Shared encodings for the three-channel timer.
package tri_timer_pkg;

    // Tick source of a channel counter.
    typedef enum logic [1:0] {
        TSRC_CYCLE = 2'b00,   // every clock
        TSRC_DIV   = 2'b01,   // shared divider tick
        TSRC_CHAIN = 2'b10,   // overflow pulse of preceding channel
        TSRC_INPUT = 2'b11    // rising edge of own input
    } tsrc_e;

    // Capture edge qualifiers, bit 0 rising, bit 1 falling.
    localparam int unsigned EDGE_RISE_BIT = 0;
    localparam int unsigned EDGE_FALL_BIT = 1;

endpackage

// File: rtl/tri_timer_div.sv
// Free-running divider: emits a one-cycle tick every DIV_RATIO cycles.
// Assumes DIV_RATIO >= 2; phase restarts at zero under reset.
module tri_timer_div #(
    parameter int unsigned DIV_RATIO = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned PW = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;

    logic [PW-1:0] phase_q;

    assign tick_o = (phase_q == PW'(DIV_RATIO - 1));

    // Advance the phase, wrapping after the last step.
    always_ff @(posedge clk) begin
        if (!rst_n)      phase_q <= '0;
        else if (tick_o) phase_q <= '0;
        else             phase_q <= phase_q + PW'(1);
    end

    AST_DIV_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o) else $error("divider tick longer than one cycle"); // R8
endmodule

// File: rtl/tri_timer_chan.sv
// One timer channel: counter, capture pair, waveform comparator, overflow.
// Assumes inputs are synchronous to clk; trigger outranks every other action.
module tri_timer_chan
    import tri_timer_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic          trig_i,
    input  logic          wave_mode_i,
    input  logic [1:0]    clk_sel_i,
    input  logic [1:0]    edge_sel_i,
    input  logic          tin_i,
    input  logic          div_tick_i,
    input  logic          chain_tick_i,
    input  logic [CW-1:0] cmp_a_i,
    input  logic [CW-1:0] cmp_c_i,
    output logic [CW-1:0] count_o,
    output logic [CW-1:0] cap_a_o,
    output logic [CW-1:0] cap_b_o,
    output logic          wave_o,
    output logic          ovf_flag_o,
    output logic          ovf_pulse_o
);
    logic  tin_q;
    logic  to_b_q;
    logic  rise, fall, tick, advance, hit_a, hit_c, restart, wrap, cap_hit;
    tsrc_e src;

    assign src  = tsrc_e'(clk_sel_i);
    assign rise = tin_i & ~tin_q;
    assign fall = ~tin_i & tin_q;

    // Pick the tick that advances this counter.
    always_comb begin
        case (src)
            TSRC_CYCLE: tick = 1'b1;
            TSRC_DIV:   tick = div_tick_i;
            TSRC_CHAIN: tick = chain_tick_i;
            default:    tick = rise;
        endcase
    end

    assign advance = enable_i & tick;
    assign hit_a   = (count_o == cmp_a_i);
    assign hit_c   = (count_o == cmp_c_i);
    assign restart = advance & wave_mode_i & hit_c;
    assign wrap    = advance & (&count_o) & ~restart;
    assign cap_hit = enable_i & ~wave_mode_i &
                     ((edge_sel_i[EDGE_RISE_BIT] & rise) | (edge_sel_i[EDGE_FALL_BIT] & fall));

    // Remember the input level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) tin_q <= 1'b0;
        else        tin_q <= tin_i;
    end

    // Counter with clear, compare-C restart and natural wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || trig_i) count_o <= '0;
        else if (restart)     count_o <= '0;
        else if (advance)     count_o <= count_o + CW'(1);
    end

    // Overflow flag and pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || trig_i) begin
            ovf_flag_o  <= 1'b0;
            ovf_pulse_o <= 1'b0;
        end else begin
            ovf_pulse_o <= wrap;
            if (wrap) ovf_flag_o <= 1'b1;
        end
    end

    // Waveform output: C clears with priority, A sets.
    always_ff @(posedge clk) begin
        if (!rst_n || trig_i)                  wave_o <= 1'b0;
        else if (advance && wave_mode_i && hit_c) wave_o <= 1'b0;
        else if (advance && wave_mode_i && hit_a) wave_o <= 1'b1;
    end

    // Alternate capture of the pre-edge count between A and B.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a_o <= '0;
            cap_b_o <= '0;
            to_b_q  <= 1'b0;
        end else if (trig_i) begin
            to_b_q  <= 1'b0;
        end else if (cap_hit) begin
            if (to_b_q) cap_b_o <= count_o;
            else        cap_a_o <= count_o;
            to_b_q <= ~to_b_q;
        end
    end

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse_o |=> !ovf_pulse_o) else $error("overflow pulse stretched"); // R7
    AST_PULSE_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse_o |-> ovf_flag_o) else $error("pulse without flag"); // R7
    AST_PULSE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse_o |-> (count_o == '0)) else $error("pulse with nonzero count"); // R2
    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && !trig_i) |=> ($stable(count_o) && $stable(wave_o))) else $error("disabled channel moved"); // R4
    AST_TRIG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> (count_o == '0 && !wave_o && !ovf_flag_o)) else $error("trigger did not clear"); // R3
endmodule

// File: rtl/tri_timer.sv
// Top: shared divider plus NCH timer channels chained in a ring by their
// overflow pulses. Assumes all inputs synchronous to clk.
module tri_timer #(
    parameter int unsigned NCH       = 3,
    parameter int unsigned CW        = 16,
    parameter int unsigned DIV_RATIO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_start_i,
    input  logic [NCH-1:0]    enable_i,
    input  logic [NCH-1:0]    trig_i,
    input  logic [NCH-1:0]    wave_mode_i,
    input  logic [2*NCH-1:0]  clk_sel_i,
    input  logic [2*NCH-1:0]  edge_sel_i,
    input  logic [NCH-1:0]    tin_i,
    input  logic [NCH*CW-1:0] cmp_a_i,
    input  logic [NCH*CW-1:0] cmp_c_i,
    output logic [NCH*CW-1:0] count_o,
    output logic [NCH*CW-1:0] cap_a_o,
    output logic [NCH*CW-1:0] cap_b_o,
    output logic [NCH-1:0]    wave_o,
    output logic [NCH-1:0]    ovf_flag_o,
    output logic [NCH-1:0]    ovf_pulse_o
);
    logic div_tick;

    tri_timer_div #(.DIV_RATIO(DIV_RATIO)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (div_tick)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int unsigned PREV = (g + NCH - 1) % NCH;
        tri_timer_chan #(.CW(CW)) u_ch (
            .clk          (clk),
            .rst_n        (rst_n),
            .enable_i     (enable_i[g]),
            .trig_i       (trig_i[g] | sync_start_i),
            .wave_mode_i  (wave_mode_i[g]),
            .clk_sel_i    (clk_sel_i[2*g +: 2]),
            .edge_sel_i   (edge_sel_i[2*g +: 2]),
            .tin_i        (tin_i[g]),
            .div_tick_i   (div_tick),
            .chain_tick_i (ovf_pulse_o[PREV]),
            .cmp_a_i      (cmp_a_i[g*CW +: CW]),
            .cmp_c_i      (cmp_c_i[g*CW +: CW]),
            .count_o      (count_o[g*CW +: CW]),
            .cap_a_o      (cap_a_o[g*CW +: CW]),
            .cap_b_o      (cap_b_o[g*CW +: CW]),
            .wave_o       (wave_o[g]),
            .ovf_flag_o   (ovf_flag_o[g]),
            .ovf_pulse_o  (ovf_pulse_o[g])
        );
    end

    AST_SYNC_ALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sync_start_i |=> (count_o == '0 && wave_o == '0)) else $error("global start missed a channel"); // R3
endmodule

// File: tb/test_tri_timer.sv
module test_tri_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;
    localparam int CW  = 16;
    localparam int DIV = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sync_start_i = 1'b0;
    logic [NCH-1:0]    enable_i = '0, trig_i = '0, wave_mode_i = '0, tin_i = '0;
    logic [2*NCH-1:0]  clk_sel_i = '0, edge_sel_i = '0;
    logic [NCH*CW-1:0] cmp_a_i = '0, cmp_c_i = '0;
    logic [NCH*CW-1:0] count_o, cap_a_o, cap_b_o;
    logic [NCH-1:0]    wave_o, ovf_flag_o, ovf_pulse_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_timer #(.NCH(NCH), .CW(CW), .DIV_RATIO(DIV)) i_tri_timer (.*);

    // Behavioural reference state.
    int m_cnt[NCH], m_ca[NCH], m_cb[NCH];
    bit m_wave[NCH], m_flag[NCH], m_pulse[NCH], m_inq[NCH], m_tob[NCH];
    int m_phase;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        bit old_p[NCH];
        bit dtick;
        if (!rst_n) begin
            m_phase = 0;
            for (int i = 0; i < NCH; i++) begin
                m_cnt[i] = 0; m_ca[i] = 0; m_cb[i] = 0; m_wave[i] = 0;
                m_flag[i] = 0; m_pulse[i] = 0; m_inq[i] = 0; m_tob[i] = 0;
            end
        end else begin
            dtick = (m_phase == DIV - 1);
            m_phase = dtick ? 0 : m_phase + 1;
            for (int i = 0; i < NCH; i++) old_p[i] = m_pulse[i];
            for (int i = 0; i < NCH; i++) begin
                bit r, f, t, hit, md;
                int sel, es, a, c;
                r   = tin_i[i] && !m_inq[i];
                f   = !tin_i[i] && m_inq[i];
                sel = clk_sel_i[2*i +: 2];
                es  = edge_sel_i[2*i +: 2];
                md  = wave_mode_i[i];
                a   = cmp_a_i[i*CW +: CW];
                c   = cmp_c_i[i*CW +: CW];
                t   = (sel == 0) ? 1'b1 : (sel == 1) ? dtick :
                      (sel == 2) ? old_p[(i + NCH - 1) % NCH] : r;
                hit = ((es & 1) && r) || ((es & 2) && f);
                if (trig_i[i] || sync_start_i) begin
                    m_cnt[i] = 0; m_wave[i] = 0; m_flag[i] = 0; m_pulse[i] = 0; m_tob[i] = 0;
                end else begin
                    m_pulse[i] = 0;
                    if (!md && enable_i[i] && hit) begin
                        if (m_tob[i]) m_cb[i] = m_cnt[i]; else m_ca[i] = m_cnt[i];
                        m_tob[i] = !m_tob[i];
                    end
                    if (enable_i[i] && t) begin
                        if (md && m_cnt[i] == a) m_wave[i] = 1;
                        if (md && m_cnt[i] == c) m_wave[i] = 0;
                        if (md && m_cnt[i] == c) m_cnt[i] = 0;
                        else if (m_cnt[i] == 65535) begin
                            m_cnt[i] = 0; m_flag[i] = 1; m_pulse[i] = 1;
                        end else m_cnt[i]++;
                    end
                end
                m_inq[i] = tin_i[i];
            end
        end
    end

    // Compare every output with the model on every falling edge.
    always @(negedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            chk("R2 count",    count_o[i*CW +: CW], m_cnt[i]);
            chk("R5 capA",     cap_a_o[i*CW +: CW], m_ca[i]);
            chk("R5 capB",     cap_b_o[i*CW +: CW], m_cb[i]);
            chk("R6 wave",     wave_o[i], m_wave[i]);
            chk("R7 flag",     ovf_flag_o[i], m_flag[i]);
            chk("R7 pulse",    ovf_pulse_o[i], m_pulse[i]);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [CW-1:0] held;
        // R1: outputs while reset is held.
        step(3);
        chk("R1 counts", count_o, 0);
        chk("R1 caps", cap_a_o | cap_b_o, 0);
        chk("R1 bits", {wave_o, ovf_flag_o, ovf_pulse_o}, 0);
        rst_n = 1'b1;

        // Mixed modes: ch0 capture both edges, ch1 waveform A=3 C=9, ch2 capture rising on divider.
        wave_mode_i = 3'b010;
        clk_sel_i   = {2'b01, 2'b00, 2'b00};
        edge_sel_i  = {2'b01, 2'b00, 2'b11};
        cmp_a_i[1*CW +: CW] = 16'd3;
        cmp_c_i[1*CW +: CW] = 16'd9;
        enable_i = 3'b111;
        step(7);
        sync_start_i = 1'b1;
        step(1);
        sync_start_i = 1'b0;
        chk("R3 sync clears all", count_o, 0);
        step(5);
        chk("R6 wave set after A", wave_o[1], 1);
        chk("R9 capture-mode channel no wave", wave_o[0], 0);
        for (int k = 0; k < 60; k++) begin
            if (k % 3 == 0) tin_i[0] = ~tin_i[0];
            if (k % 5 == 0) tin_i[2] = ~tin_i[2];
            step(1);
        end

        // R4: disabled channel ignores ticks and edges.
        enable_i[0] = 1'b0;
        held = count_o[0 +: CW];
        for (int k = 0; k < 10; k++) begin
            tin_i[0] = ~tin_i[0];
            step(1);
        end
        chk("R4 held count", count_o[0 +: CW], held);
        enable_i[0] = 1'b1;

        // R6 corner: A equals C keeps output low; R3 single-channel trigger.
        cmp_a_i[1*CW +: CW] = 16'd7;
        cmp_c_i[1*CW +: CW] = 16'd7;
        step(25);
        trig_i[1] = 1'b1;
        step(1);
        trig_i[1] = 1'b0;
        chk("R3 trig ch1", count_o[1*CW +: CW], 0);
        chk("R3 ch0 untouched", (count_o[0 +: CW] != 0), 1);

        // Wrap and chaining: ch0 every cycle, ch1 chained, ch2 counts own rising edges.
        wave_mode_i = 3'b000;
        clk_sel_i   = {2'b11, 2'b10, 2'b00};
        edge_sel_i  = {2'b00, 2'b00, 2'b00};
        sync_start_i = 1'b1;
        step(1);
        sync_start_i = 1'b0;
        for (int k = 0; k < 65536; k++) begin
            if (k % 4 == 0) tin_i[2] = ~tin_i[2];
            step(1);
        end
        chk("R7 pulse at wrap", ovf_pulse_o[0], 1);
        chk("R7 flag at wrap", ovf_flag_o[0], 1);
        chk("R2 wrapped to zero", count_o[0 +: CW], 0);
        step(1);
        chk("R8 chained tick", count_o[1*CW +: CW], 1);
        chk("R7 pulse one cycle", ovf_pulse_o[0], 0);
        chk("R8 input-edge count", count_o[2*CW +: CW], 8192);
        step(4);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 190000);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule